// File: doc/BRIEF.md
# UART Receiver with Hysteretic RTS Flow Control

This block is the receive half of an asynchronous serial port. It watches the serial input at sixteen samples per bit period. It confirms a start bit at the middle of that bit, then samples each data bit, the optional parity bit and the stop bit at their centres. Each finished character goes into a small first-in first-out store, together with its own parity and framing error flags. Software reads the store through a show-ahead port: the oldest character is always on the outputs, and a one-cycle read strobe removes it.

The block throttles the remote transmitter with an active-low request-to-send output, and that output has hysteresis. It goes inactive (high) once the number of stored characters reaches a programmable trigger level. It becomes active (low) again only after the store has been drained completely, not as soon as one slot frees up. When flow control is switched off, the output stays high. The oversampling tick comes from outside, so baud-rate generation is not part of this block.

Top module: `uart_rx_flow`

## Requirements
- R1: A frame is one low start bit, then 6, 7 or 8 data bits least-significant bit first, then an optional parity bit, then a high stop bit. The data length code `cfg_len_i` selects the count: 0 gives 6 bits, 1 gives 7 bits, and 2 or 3 give 8 bits. Data bits above the selected length read as zero in `rd_data_o`.
- R2: A bit period is 16 baud ticks. A falling edge starts a frame only if the line is still low when sampled 8 ticks later. A low pulse shorter than half a bit stores nothing.
- R3: When `cfg_par_en_i` is 1, the parity bit is checked: even parity when `cfg_par_odd_i` is 0, odd parity when it is 1. On a mismatch, `rd_perr_o` is 1 for that character. When parity is disabled, no parity bit is expected and `rd_perr_o` is 0.
- R4: A stop bit sampled low sets `rd_ferr_o` for that character, and the character is still stored.
- R5: The store holds 8 characters. `rd_data_o`, `rd_perr_o` and `rd_ferr_o` show the oldest one. A read strobe with a non-empty store removes exactly one character. A read strobe with an empty store is ignored. `fill_o` is the number of stored characters.
- R6: A character that completes while the store is full and no read happens in the same cycle is dropped, and `overrun_o` is high for exactly the following cycle. If a read happens in that same cycle, the character is accepted and the store stays full.
- R7: With flow control enabled and `rts_n_o` low, `rts_n_o` goes high one cycle after `fill_o` reaches the trigger level. A trigger code of 0 counts as 1, and a code above 8 counts as 8.
- R8: With flow control enabled, once `rts_n_o` is high it stays high while `fill_o` is non-zero, and it goes low one cycle after `fill_o` is 0.
- R9: While `cfg_fc_en_i` is 0, `rts_n_o` is high from the following cycle on.
- R10: During reset, `fill_o` is 0, `rts_n_o` is 1 and `overrun_o` is 0.
- R11: With the baud tick high on every clock, suppose a frame's start bit is first driven just after clock edge E. The character then counts in `fill_o` after edge E + 28 + 16 × (data bits + parity bits). This includes two synchronizer stages and one store stage.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_i | input | 1 | Serial receive line, idle high |
| baud_tick_i | input | 1 | Oversampling tick, 16 per bit period |
| cfg_len_i | input | 2 | Data length code (0:6, 1:7, 2/3:8 bits) |
| cfg_par_en_i | input | 1 | Parity bit present and checked |
| cfg_par_odd_i | input | 1 | 1 selects odd parity, 0 even |
| cfg_trig_i | input | 4 | Store fill level that releases RTS |
| cfg_fc_en_i | input | 1 | Flow control enable |
| rd_i | input | 1 | Read strobe, removes the oldest character |
| rd_data_o | output | 8 | Oldest stored character |
| rd_perr_o | output | 1 | Parity error flag of the oldest character |
| rd_ferr_o | output | 1 | Framing error flag of the oldest character |
| fill_o | output | 4 | Number of stored characters |
| overrun_o | output | 1 | One-cycle pulse when a character is dropped |
| rts_n_o | output | 1 | Request to send, active low |

## Verification
The bench goes after the hysteresis. It reads out part of the data above the trigger level, then the last character, and checks that RTS stays high until the store is empty. A design that compared only against the trigger level would drop RTS too early. The bench also sends a short low glitch, which a design without the mid-bit check would turn into a spurious character. It corrupts parity bits in both parity senses at 6- and 7-bit lengths, where a design with the wrong bit count or inverted parity would flag the wrong characters. It overfills the store, including a character that lands in the same cycle as a read; a wrong full test there would either lose that character or corrupt the oldest entry.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_START,
      ST_DATA,
      ST_PAR,
      ST_STOP
   } rx_state_e;

   typedef struct packed {
      logic [7:0] data;
      logic       perr;
      logic       ferr;
   } rx_word_t;

   localparam int WORD_W = $bits(rx_word_t);

   // data length code to bit count (R1)
   function automatic logic [3:0] data_bits(input logic [1:0] code);
      case (code)
         2'd0:    return 4'd6;
         2'd1:    return 4'd7;
         default: return 4'd8;
      endcase
   endfunction

endpackage

// File: rtl/uart_rx_sync.sv
module uart_rx_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_i,
   output logic q_o
);
   logic [STAGES-1:0] chain;

   generate
      for (genvar s = 0; s < STAGES; s++) begin : g_stage
         if (s == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain[0] <= 1'b1;
               else        chain[0] <= d_i;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain[s] <= 1'b1;
               else        chain[s] <= chain[s-1];
            end
         end
      end
   endgenerate

   assign q_o = chain[STAGES-1];
endmodule

// File: rtl/uart_rx_deser.sv
module uart_rx_deser
   import uart_rx_pkg::*;
#(
   parameter int OVS = 16
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       rx_s_i,
   input  logic       tick_i,
   input  logic [1:0] len_i,
   input  logic       par_en_i,
   input  logic       par_odd_i,
   output logic       valid_o,
   output rx_word_t   word_o
);
   localparam int CW = $clog2(OVS);
   localparam logic [CW-1:0] MID  = CW'(OVS / 2 - 1);
   localparam logic [CW-1:0] LAST = CW'(OVS - 1);

   rx_state_e     st;
   logic [CW-1:0] cnt;
   logic [2:0]    idx;
   logic [7:0]    shreg;
   logic          par_acc;
   logic          perr_q;
   logic [3:0]    nbits;
   logic          at_mid;
   logic          at_end;

   assign nbits  = data_bits(len_i);
   assign at_mid = tick_i && (cnt == MID);
   assign at_end = tick_i && (cnt == LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st      <= ST_IDLE;
         cnt     <= '0;
         idx     <= '0;
         shreg   <= '0;
         par_acc <= 1'b0;
         perr_q  <= 1'b0;
         valid_o <= 1'b0;
         word_o  <= '0;
      end else begin
         valid_o <= 1'b0;
         if (tick_i && st != ST_IDLE) cnt <= cnt + 1'b1;
         case (st)
            ST_IDLE: begin
               if (tick_i && !rx_s_i) begin
                  st  <= ST_START;
                  cnt <= '0;
               end
            end
            ST_START: begin
               if (at_mid) begin
                  cnt <= '0;
                  if (!rx_s_i) begin
                     st      <= ST_DATA;
                     idx     <= '0;
                     shreg   <= '0;
                     par_acc <= 1'b0;
                     perr_q  <= 1'b0;
                  end else begin
                     st <= ST_IDLE;
                  end
               end
            end
            ST_DATA: begin
               if (at_end) begin
                  shreg[idx] <= rx_s_i;
                  par_acc    <= par_acc ^ rx_s_i;
                  if ({1'b0, idx} == nbits - 4'd1) begin
                     st <= par_en_i ? ST_PAR : ST_STOP;
                  end else begin
                     idx <= idx + 3'd1;
                  end
               end
            end
            ST_PAR: begin
               if (at_end) begin
                  perr_q <= (rx_s_i != (par_acc ^ par_odd_i));
                  st     <= ST_STOP;
               end
            end
            ST_STOP: begin
               if (at_end) begin
                  valid_o     <= 1'b1;
                  word_o.data <= shreg;
                  word_o.perr <= perr_q;
                  word_o.ferr <= !rx_s_i;
                  st          <= ST_IDLE;
               end
            end
            default: st <= ST_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/uart_rx_fifo.sv
module uart_rx_fifo
   import uart_rx_pkg::*;
#(
   parameter int DEPTH = 8,
   parameter int CNT_W = $clog2(DEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             push_i,
   input  rx_word_t         word_i,
   input  logic             pop_i,
   output rx_word_t         head_o,
   output logic [CNT_W-1:0] count_o,
   output logic             overrun_o
);
   localparam int AW = $clog2(DEPTH);
   localparam logic [CNT_W-1:0] FULL = CNT_W'(DEPTH);

   rx_word_t        mem [DEPTH];
   logic [AW-1:0]   wptr;
   logic [AW-1:0]   rptr;
   logic            pop_ok;
   logic            push_ok;

   assign pop_ok  = pop_i && (count_o != '0);
   assign push_ok = push_i && ((count_o != FULL) || pop_ok);
   assign head_o  = mem[rptr];

   always_ff @(posedge clk) begin
      if (push_ok) mem[wptr] <= word_i;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wptr      <= '0;
         rptr      <= '0;
         count_o   <= '0;
         overrun_o <= 1'b0;
      end else begin
         overrun_o <= push_i && !push_ok;
         if (push_ok) wptr <= wptr + 1'b1;
         if (pop_ok)  rptr <= rptr + 1'b1;
         case ({push_ok, pop_ok})
            2'b10:   count_o <= count_o + 1'b1;
            2'b01:   count_o <= count_o - 1'b1;
            default: count_o <= count_o;
         endcase
      end
   end
endmodule

// File: rtl/uart_rx_rts.sv
module uart_rx_rts #(
   parameter int DEPTH = 8,
   parameter int CNT_W = $clog2(DEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             fc_en_i,
   input  logic [CNT_W-1:0] trig_i,
   input  logic [CNT_W-1:0] count_i,
   output logic             rts_n_o
);
   localparam logic [CNT_W-1:0] FULL = CNT_W'(DEPTH);
   logic [CNT_W-1:0] trig_eff;

   always_comb begin
      if (trig_i == '0)      trig_eff = CNT_W'(1);
      else if (trig_i > FULL) trig_eff = FULL;
      else                   trig_eff = trig_i;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rts_n_o <= 1'b1;
      end else if (!fc_en_i) begin
         rts_n_o <= 1'b1;
      end else if (rts_n_o) begin
         if (count_i == '0) rts_n_o <= 1'b0;
      end else if (count_i >= trig_eff) begin
         rts_n_o <= 1'b1;
      end
   end
endmodule

// File: rtl/uart_rx_flow.sv
module uart_rx_flow
   import uart_rx_pkg::*;
#(
   parameter int DEPTH       = 8,
   parameter int OVS         = 16,
   parameter int SYNC_STAGES = 2,
   parameter int CNT_W       = $clog2(DEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             rx_i,
   input  logic             baud_tick_i,
   input  logic [1:0]       cfg_len_i,
   input  logic             cfg_par_en_i,
   input  logic             cfg_par_odd_i,
   input  logic [CNT_W-1:0] cfg_trig_i,
   input  logic             cfg_fc_en_i,
   input  logic             rd_i,
   output logic [7:0]       rd_data_o,
   output logic             rd_perr_o,
   output logic             rd_ferr_o,
   output logic [CNT_W-1:0] fill_o,
   output logic             overrun_o,
   output logic             rts_n_o
);
   generate
      if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
         $error("DEPTH must be a power of two of at least 2");
      end
      if (OVS < 4 || (OVS & (OVS - 1)) != 0) begin : g_bad_ovs
         $error("OVS must be a power of two of at least 4");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("SYNC_STAGES must be at least 2");
      end
      if (CNT_W < $clog2(DEPTH + 1)) begin : g_bad_cnt
         $error("CNT_W too narrow for DEPTH");
      end
   endgenerate

   logic     rx_s;
   logic     rx_push;
   rx_word_t rx_word;
   rx_word_t head;

   uart_rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   (rx_i),
      .q_o   (rx_s)
   );

   uart_rx_deser #(.OVS(OVS)) u_deser (
      .clk       (clk),
      .rst_n     (rst_n),
      .rx_s_i    (rx_s),
      .tick_i    (baud_tick_i),
      .len_i     (cfg_len_i),
      .par_en_i  (cfg_par_en_i),
      .par_odd_i (cfg_par_odd_i),
      .valid_o   (rx_push),
      .word_o    (rx_word)
   );

   uart_rx_fifo #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_fifo (
      .clk       (clk),
      .rst_n     (rst_n),
      .push_i    (rx_push),
      .word_i    (rx_word),
      .pop_i     (rd_i),
      .head_o    (head),
      .count_o   (fill_o),
      .overrun_o (overrun_o)
   );

   uart_rx_rts #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_rts (
      .clk     (clk),
      .rst_n   (rst_n),
      .fc_en_i (cfg_fc_en_i),
      .trig_i  (cfg_trig_i),
      .count_i (fill_o),
      .rts_n_o (rts_n_o)
   );

   assign rd_data_o = head.data;
   assign rd_perr_o = head.perr;
   assign rd_ferr_o = head.ferr;
endmodule

// File: rtl/uart_rx_flow_chk.sv
module uart_rx_flow_chk #(
   parameter int DEPTH = 8,
   parameter int CNT_W = 4
) (
   input logic             clk,
   input logic             rst_n,
   input logic             rd_i,
   input logic             push_i,
   input logic             cfg_fc_en_i,
   input logic [CNT_W-1:0] cfg_trig_i,
   input logic [CNT_W-1:0] fill_o,
   input logic             overrun_o,
   input logic             rts_n_o
);
   int trig_eff;
   assign trig_eff = (cfg_trig_i == '0) ? 1 :
                     (int'(cfg_trig_i) > DEPTH) ? DEPTH : int'(cfg_trig_i);

   assert_fill_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
      int'(fill_o) <= DEPTH);

   assert_fill_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (int'(fill_o) - int'($past(fill_o)) <= 1) &&
               (int'($past(fill_o)) - int'(fill_o) <= 1));

   assert_empty_read_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (fill_o == '0 && !push_i) |=> fill_o == '0);

   assert_drop_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (push_i && int'(fill_o) == DEPTH && !rd_i) |=> overrun_o && int'(fill_o) == DEPTH);

   assert_rts_rise_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_fc_en_i && !rts_n_o && int'(fill_o) >= trig_eff) |=> rts_n_o);

   assert_rts_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_fc_en_i && rts_n_o && fill_o != '0) |=> rts_n_o);

   assert_rts_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_fc_en_i && rts_n_o && fill_o == '0) |=> !rts_n_o);

   assert_rts_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_fc_en_i |=> rts_n_o);
endmodule

bind uart_rx_flow uart_rx_flow_chk #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .rd_i        (rd_i),
   .push_i      (rx_push),
   .cfg_fc_en_i (cfg_fc_en_i),
   .cfg_trig_i  (cfg_trig_i),
   .fill_o      (fill_o),
   .overrun_o   (overrun_o),
   .rts_n_o     (rts_n_o)
);

// File: tb/uart_rx_flow_tb.sv
module uart_rx_flow_tb;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       rx = 1'b1;
   logic       tick = 1'b1;
   logic [1:0] len = 2'd2;
   logic       par_en = 1'b0;
   logic       par_odd = 1'b0;
   logic [3:0] trig = 4'd4;
   logic       fc_en = 1'b1;
   logic       rd = 1'b0;
   logic [7:0] rd_data;
   logic       rd_perr, rd_ferr, ovr;
   logic [3:0] fill;
   logic       rts_n;

   int n_checks = 0;
   int n_fail   = 0;
   int cyc      = 0;
   bit done     = 1'b0;

   // reference model state
   bit [9:0] q[$];
   int       pend_edge[$];
   bit [9:0] pend_word[$];
   bit       rts_m = 1'b1;
   bit       ovr_m = 1'b0;

   always #4 clk = ~clk;

   uart_rx_flow u_dut (
      .clk (clk), .rst_n (rst_n), .rx_i (rx), .baud_tick_i (tick),
      .cfg_len_i (len), .cfg_par_en_i (par_en), .cfg_par_odd_i (par_odd),
      .cfg_trig_i (trig), .cfg_fc_en_i (fc_en), .rd_i (rd),
      .rd_data_o (rd_data), .rd_perr_o (rd_perr), .rd_ferr_o (rd_ferr),
      .fill_o (fill), .overrun_o (ovr), .rts_n_o (rts_n)
   );

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s at cycle %0d: actual=%0d expected=%0d", req, what, cyc, act, exp);
      end
   endtask

   function automatic int trig_eff();
      if (trig == 0) return 1;
      if (trig > 8)  return 8;
      return int'(trig);
   endfunction

   // behavioural model, advanced on every edge
   always @(posedge clk) begin
      cyc++;
      if (!rst_n) begin
         q.delete();
         rts_m = 1'b1;
         ovr_m = 1'b0;
      end else begin
         bit push, pop, drop;
         bit [9:0] w;
         if (!fc_en)     rts_m = 1'b1;
         else if (rts_m) rts_m = (q.size() != 0);
         else            rts_m = (q.size() >= trig_eff());
         push = (pend_edge.size() > 0) && (pend_edge[0] == cyc);
         pop  = rd && (q.size() > 0);
         drop = push && (q.size() == 8) && !pop;
         ovr_m = drop;
         if (pop) void'(q.pop_front());
         if (push) begin
            void'(pend_edge.pop_front());
            w = pend_word.pop_front();
            if (!drop) q.push_back(w);
         end
      end
   end

   // compare on every clock, away from the active edge
   always @(negedge clk) begin
      if (rst_n && !done) begin
         chk(int'(fill) == q.size(), "R5 R11", "fill level", int'(fill), q.size());
         chk(rts_n == rts_m, "R8", "rts_n", int'(rts_n), int'(rts_m));
         chk(ovr == ovr_m, "R6", "overrun", int'(ovr), int'(ovr_m));
         if (q.size() > 0) begin
            chk(rd_data == q[0][9:2], "R1", "read data", int'(rd_data), int'(q[0][9:2]));
            chk(rd_perr == q[0][1], "R3", "parity flag", int'(rd_perr), int'(q[0][1]));
            chk(rd_ferr == q[0][0], "R4", "framing flag", int'(rd_ferr), int'(q[0][0]));
         end
      end
   end

   task automatic send_frame(input bit [7:0] d, input bit bad_par, input bit bad_stop);
      int n, p, e0;
      bit [7:0] m, dm;
      bit pbit;
      n  = (len == 0) ? 6 : (len == 1) ? 7 : 8;
      p  = par_en ? 1 : 0;
      m  = 8'hFF >> (8 - n);
      dm = d & m;
      pbit = (^dm) ^ par_odd ^ bad_par;
      @(negedge clk);
      e0 = cyc;
      pend_edge.push_back(e0 + 28 + 16 * (n + p));
      pend_word.push_back({dm, par_en & bad_par, bad_stop});
      rx = 1'b0;
      repeat (16) @(negedge clk);
      for (int i = 0; i < n; i++) begin
         rx = dm[i];
         repeat (16) @(negedge clk);
      end
      if (p != 0) begin
         rx = pbit;
         repeat (16) @(negedge clk);
      end
      rx = !bad_stop;
      repeat (16) @(negedge clk);
      rx = 1'b1;
      repeat (40) @(negedge clk);
   endtask

   task automatic rd_one();
      @(negedge clk);
      rd = 1'b1;
      @(negedge clk);
      rd = 1'b0;
   endtask

   task automatic drain();
      while (q.size() > 0) rd_one();
      repeat (3) @(negedge clk);
   endtask

   task automatic finish_run();
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   endtask

   initial begin
      repeat (4) @(negedge clk);
      // R10: reset state
      chk(fill == 0, "R10", "fill in reset", int'(fill), 0);
      chk(rts_n == 1'b1, "R10", "rts_n in reset", int'(rts_n), 1);
      chk(ovr == 1'b0, "R10", "overrun in reset", int'(ovr), 0);
      rst_n = 1'b1;
      repeat (4) @(negedge clk);

      // R7 R8 hysteresis with trigger 4, 8-bit frames
      send_frame(8'hA5, 0, 0);
      send_frame(8'h3C, 0, 0);
      send_frame(8'hFF, 0, 0);
      chk(rts_n == 1'b0, "R7", "rts below trigger", int'(rts_n), 0);
      send_frame(8'h01, 0, 0);
      chk(rts_n == 1'b1, "R7", "rts at trigger", int'(rts_n), 1);
      rd_one(); rd_one(); rd_one();
      repeat (2) @(negedge clk);
      chk(rts_n == 1'b1, "R8", "rts held with one left", int'(rts_n), 1);
      drain();
      chk(rts_n == 1'b0, "R8", "rts after drain", int'(rts_n), 0);

      // R1 R3: 6- and 7-bit frames with even and odd parity
      len = 2'd0; par_en = 1'b1; par_odd = 1'b0;
      send_frame(8'hEB, 0, 0);
      send_frame(8'h15, 1, 0);
      len = 2'd1; par_odd = 1'b1;
      send_frame(8'h9A, 0, 0);
      send_frame(8'h40, 1, 0);
      drain();

      // R4: framing error, 8 bits no parity
      len = 2'd2; par_en = 1'b0;
      send_frame(8'h5A, 0, 1);
      send_frame(8'hC3, 0, 0);
      drain();

      // R2: short glitch must store nothing
      @(negedge clk); rx = 1'b0;
      repeat (4) @(negedge clk); rx = 1'b1;
      repeat (60) @(negedge clk);
      chk(fill == 0, "R2", "glitch stored nothing", int'(fill), 0);

      // R7: trigger code 0 behaves as 1
      trig = 4'd0;
      send_frame(8'h77, 0, 0);
      chk(rts_n == 1'b1, "R7", "rts with trigger 0", int'(rts_n), 1);
      drain();

      // R9: flow control off
      fc_en = 1'b0;
      repeat (2) @(negedge clk);
      chk(rts_n == 1'b1, "R9", "rts with flow control off", int'(rts_n), 1);
      send_frame(8'h11, 0, 0);
      drain();
      chk(rts_n == 1'b1, "R9", "rts off while empty", int'(rts_n), 1);
      fc_en = 1'b1;

      // R5 R6: overfill with trigger 8
      trig = 4'd8;
      for (int k = 0; k < 8; k++) send_frame(8'(8'h20 + k), 0, 0);
      chk(fill == 4'd8, "R5", "full store", int'(fill), 8);
      send_frame(8'hEE, 0, 0);
      chk(fill == 4'd8, "R6", "dropped byte", int'(fill), 8);
      fork
         send_frame(8'hD1, 0, 0);
         begin
            wait (pend_edge.size() > 0);
            while (cyc != pend_edge[0] - 1) @(negedge clk);
            rd = 1'b1;
            @(negedge clk);
            rd = 1'b0;
         end
      join
      chk(fill == 4'd8, "R6", "push with read when full", int'(fill), 8);
      drain();

      // R5: read strobe on empty store is ignored
      rd_one(); rd_one();
      repeat (2) @(negedge clk);
      chk(fill == 0, "R5", "read on empty", int'(fill), 0);
      send_frame(8'h6D, 0, 0);
      chk(rd_data == 8'h6D, "R5", "data after empty reads", int'(rd_data), 'h6D);
      drain();

      finish_run();
   end

   initial begin
      repeat (150000) @(posedge clk);
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: run still active, actual cycle=%0d expected below 150000", cyc);
      finish_run();
   end
endmodule